// File: doc/BRIEF.md
# Single-wire slot-start deglitch filter

This block sits between an already synchronised single-wire bus input and the time-slot logic of a bus slave. It turns the raw sampled line into a filtered line level and a one-cycle pulse that marks the start of each genuine time slot. High-frequency noise is rejected in two ways.

First, every accepted rising edge opens a hold-off window of a fixed number of clock cycles. Low samples seen inside that window are ignored however long or deep they are, provided they end before the window does. Second, at standard speed a falling edge must be held low for a minimum number of consecutive cycles before it counts as a slot start. At overdrive speed this second filter is bypassed, so the first low sample after the window is accepted.

A requested speed change is taken up only while the filtered line is high, no window is running and no low candidate is being timed. A change therefore never lands in the middle of a slot.

Top module: `slot_edge_filter`

## Requirements
- R1: After synchronous reset (`rst`=1 at a clock edge) `line_filt` is 1, `slot_start` is 0, no hold-off window is active and the mode is standard. A low line seen after reset is therefore filtered without any hold-off.
- R2: In standard mode, a low on `line_in` sampled on MIN_LOW consecutive edges outside the window drives `line_filt` to 0 and `slot_start` to 1 right after the MIN_LOW-th of those edges.
- R3: In standard mode, a low run of fewer than MIN_LOW samples that returns high is discarded. `line_filt` stays 1 and no pulse is produced.
- R4: When `line_filt` is 0 and `line_in`=1 is sampled at edge j, a hold-off window opens. Low samples at edges j+1 through j+HOLD_CYC are ignored at any speed.
- R5: A low that starts inside the window and is still present after it is a slot start. It is timed from edge j+HOLD_CYC+1 by the filter of the current mode.
- R6: In overdrive mode, the first low sample outside the window gives `line_filt`=0 and `slot_start`=1 right after that edge.
- R7: `slot_start` is high for exactly one cycle per accepted falling edge. It does not fire again until a rising edge has been accepted, however long the line stays low.
- R8: `speed_fast_req` (1 = overdrive, 0 = standard) is latched only on an edge where `line_filt`=1, no window is active, no low candidate is pending and `line_in`=1. A change made during a pending low has no effect on that low.
- R9: `line_filt` returns to 1 right after the first edge at which `line_in`=1 is sampled while `line_filt` is 0, at either speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Synchronised bus line sample |
| speed_fast_req | input | 1 | Requested speed: 1 overdrive, 0 standard |
| slot_start | output | 1 | One-cycle pulse at an accepted slot start |
| line_filt | output | 1 | Filtered line level |

## Verification
The end of the hold-off window and a low sample can fall on neighbouring edges. The bench holds the line low from the cycle after a rising edge, so the last ignored sample and the first counted one are adjacent. It then checks, in both modes, that the pulse appears exactly HOLD_CYC plus the mode's filter length after that rise, and not one cycle earlier. A speed request that arrives together with a pending low candidate is also provoked. That low must still be timed by the standard filter.

// File: rtl/slot_edge_filter.sv
module slot_edge_filter #(
  parameter int HOLD_CYC = 6,
  parameter int MIN_LOW  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic speed_fast_req,
  output logic slot_start,
  output logic line_filt
);
  localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
  localparam int LW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);

  logic [HW-1:0] hold_cnt;
  logic [LW-1:0] low_cnt;
  logic          fast_mode;

  wire window = hold_cnt != '0;
  wire idle   = line_filt && !window;
  wire accept = idle && !line_in && (fast_mode || low_cnt == LW'(MIN_LOW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_filt  <= 1'b1;
      slot_start <= 1'b0;
      hold_cnt   <= '0;
      low_cnt    <= '0;
      fast_mode  <= 1'b0;
    end else begin
      slot_start <= accept;
      if (!line_filt) begin
        low_cnt <= '0;
        if (line_in) begin
          line_filt <= 1'b1;
          hold_cnt  <= HW'(HOLD_CYC);
        end
      end else if (window) begin
        hold_cnt <= hold_cnt - 1'b1;
        low_cnt  <= '0;
      end else if (line_in) begin
        if (low_cnt == '0) fast_mode <= speed_fast_req;
        low_cnt <= '0;
      end else if (accept) begin
        line_filt <= 1'b0;
        low_cnt   <= '0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end
endmodule

module slot_edge_filter_chk #(
  parameter int HOLD_CYC = 6,
  parameter int MIN_LOW  = 4
) (
  input logic clk,
  input logic rst,
  input logic line_in,
  input logic slot_start,
  input logic line_filt,
  input logic fast_mode
);
  localparam int CW = $clog2(HOLD_CYC + MIN_LOW + 3) + 1;
  logic [CW-1:0] low_run;
  logic [CW-1:0] since_rise;
  logic          was_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run    <= '0;
      since_rise <= CW'(HOLD_CYC + 1);
      was_rst    <= 1'b1;
    end else begin
      was_rst    <= 1'b0;
      low_run    <= line_in ? '0 : ((low_run < CW'(MIN_LOW)) ? low_run + 1'b1 : low_run);
      since_rise <= !line_filt ? '0 :
                    ((since_rise < CW'(HOLD_CYC + 1)) ? since_rise + 1'b1 : since_rise);
    end
  end

  a_r2_std_min_low: assert property (@(posedge clk) disable iff (rst)
    (slot_start && !fast_mode) |-> (low_run >= CW'(MIN_LOW)));
  a_r4_holdoff: assert property (@(posedge clk) disable iff (rst)
    slot_start |-> (since_rise >= CW'(HOLD_CYC + 1)));
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> !slot_start);
  a_r7_fall_pulse: assert property (@(posedge clk) disable iff (rst || was_rst)
    $fell(line_filt) |-> slot_start);
  a_r7_pulse_low: assert property (@(posedge clk) disable iff (rst)
    slot_start |-> !line_filt);
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !line_filt |=> $stable(fast_mode));
  a_r9_rise_src: assert property (@(posedge clk) disable iff (rst || was_rst)
    $rose(line_filt) |-> $past(line_in));
endmodule

bind slot_edge_filter slot_edge_filter_chk #(.HOLD_CYC(HOLD_CYC), .MIN_LOW(MIN_LOW)) u_chk (
  .clk(clk), .rst(rst), .line_in(line_in), .slot_start(slot_start),
  .line_filt(line_filt), .fast_mode(fast_mode)
);

// File: tb/tb_slot_edge_filter.sv
module tb_slot_edge_filter;
  localparam int HOLD = 6;
  localparam int MINL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_in = 1'b1;
  logic speed_fast_req = 1'b0;
  logic slot_start, line_filt;
  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_edge_filter #(.HOLD_CYC(HOLD), .MIN_LOW(MINL)) dut (
    .clk(clk), .rst(rst), .line_in(line_in), .speed_fast_req(speed_fast_req),
    .slot_start(slot_start), .line_filt(line_filt)
  );

  always @(negedge clk) if (slot_start === 1'b1) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle_high();
    line_in = 1'b1;
    edges(HOLD + 3);
  endtask

  task automatic std_slot();
    line_in = 1'b0;
    edges(MINL + 1);
  endtask

  task automatic t_reset();
    line_in = 1'b0;
    rst = 1'b1;
    edges(2);
    chk(line_filt == 1'b1, "R1 filt", line_filt, 1);
    chk(slot_start == 1'b0, "R1 pulse", slot_start, 0);
    rst = 1'b0;
    edges(MINL - 1);
    chk(line_filt == 1'b1, "R1 still filtering", line_filt, 1);
    edges(1);
    chk(slot_start == 1'b1, "R1 no hold-off after reset", slot_start, 1);
    idle_high();
  endtask

  task automatic t_std_valid();
    int p0;
    p0 = pulses;
    line_in = 1'b0;
    edges(MINL - 1);
    chk(line_filt == 1'b1 && slot_start == 1'b0, "R2 early", line_filt, 1);
    edges(1);
    chk(line_filt == 1'b0, "R2 filt", line_filt, 0);
    chk(slot_start == 1'b1, "R2 pulse", slot_start, 1);
    edges(1);
    chk(slot_start == 1'b0, "R7 one cycle", slot_start, 0);
    edges(20);
    chk(pulses - p0 == 1, "R7 single pulse on long low", pulses - p0, 1);
    line_in = 1'b1;
    edges(1);
    chk(line_filt == 1'b1, "R9 rise std", line_filt, 1);
    edges(HOLD + 2);
  endtask

  task automatic t_short();
    int p0;
    p0 = pulses;
    line_in = 1'b0;
    edges(MINL - 1);
    line_in = 1'b1;
    edges(3);
    chk(line_filt == 1'b1, "R3 filt", line_filt, 1);
    chk(pulses == p0, "R3 no pulse", pulses - p0, 0);
  endtask

  task automatic t_holdoff(input bit fast);
    int p0;
    std_slot();
    line_in = 1'b1;
    edges(1);
    p0 = pulses;
    line_in = 1'b0;
    edges(HOLD);
    line_in = 1'b1;
    edges(4);
    chk(pulses == p0, fast ? "R4 overdrive glitch" : "R4 std glitch", pulses - p0, 0);
    chk(line_filt == 1'b1, "R4 filt high", line_filt, 1);
  endtask

  task automatic t_extend(input bit fast);
    int n;
    n = fast ? HOLD + 1 : HOLD + MINL;
    std_slot();
    line_in = 1'b1;
    edges(1);
    chk(line_filt == 1'b1, "R9 rise", line_filt, 1);
    line_in = 1'b0;
    edges(n - 1);
    chk(slot_start == 1'b0 && line_filt == 1'b1, "R5 not yet", slot_start, 0);
    edges(1);
    chk(slot_start == 1'b1, fast ? "R5 R6 overdrive late low" : "R5 std late low", slot_start, 1);
    line_in = 1'b1;
    edges(HOLD + 3);
  endtask

  task automatic t_fast();
    speed_fast_req = 1'b1;
    idle_high();
    line_in = 1'b0;
    edges(1);
    chk(slot_start == 1'b1, "R6 pulse", slot_start, 1);
    chk(line_filt == 1'b0, "R6 filt", line_filt, 0);
    idle_high();
  endtask

  task automatic t_midchange();
    speed_fast_req = 1'b0;
    idle_high();
    line_in = 1'b0;
    edges(1);
    speed_fast_req = 1'b1;
    edges(MINL - 2);
    chk(slot_start == 1'b0 && line_filt == 1'b1, "R8 held standard", slot_start, 0);
    edges(1);
    chk(slot_start == 1'b1, "R8 std timing kept", slot_start, 1);
    speed_fast_req = 1'b0;
    idle_high();
  endtask

  initial begin
    edges(3);
    chk(line_filt == 1'b1 && slot_start == 1'b0, "R1 reset state", line_filt, 1);
    rst = 1'b0;
    idle_high();
    t_std_valid();
    t_short();
    t_holdoff(1'b0);
    t_extend(1'b0);
    t_fast();
    speed_fast_req = 1'b1;
    t_holdoff(1'b1);
    idle_high();
    t_extend(1'b1);
    t_midchange();
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule